// File: doc/BRIEF.md
# MII PHY Port Selection Controller

This block sits between an Ethernet MAC and two possible physical layers: a PHY on the same die, and an external MII port on pins. One 16-bit host register sets three things. It chooses which pair of receive and transmit clocks reaches the MAC. It routes the MAC's serial management port (MDC and MDIO) to one side and holds the other side idle. It also enables the external data port. These three selections are independent of each other.

The block also provides two reset services. On the first cycle after hard reset it samples the external MDIO pin as a presence strap, and software can read the result. It also carries out soft-reset requests. A request completes, and pulses a reset output for one cycle, only while the clocks feeding the MAC are toggling. If those clocks stay quiet for too long, the request is abandoned and a sticky timeout flag is raised. No interface here moves streamed data, so every pin is a plain control or status signal. Bus writes take effect at once and are never back-pressured.

Top module: `phy_port_sel`

## Requirements
- R1: Register bits 15:7 always read as zero. Read data is registered: `bus_rdata` shows the register addressed in the previous cycle. Any address other than `CTRL_ADDR` (default 0) reads as zero.
- R2: The clock select field sits at bits 6:5 and resets to 00. Codes 00 and 11 pass the internal PHY clocks to `mac_rx_clk`/`mac_tx_clk`, code 01 passes the external clocks, and code 10 holds both outputs low.
- R3: The clock select field has no effect on management-port routing or on `ext_port_en`.
- R4: While the management select bit (bit 4, reset 0) is 0, `mac_mdc` and the MAC's MDIO output and enable go to the internal PHY, and `mac_mdio_i` comes from `int_mdio_i`. In this state `ext_mdc` is 0 and `ext_mdio_oe` is 0.
- R5: While bit 4 is 1, the MAC's MDC and MDIO go to the external pins, and `mac_mdio_i` comes from `ext_mdio_i`. In this state `int_mdc` is 0, `int_mdio_o` is 0 and `int_mdio_oe` is 1. This routing does not depend on bit 2.
- R6: Bit 3 is read-only. It holds the level of `ext_mdio_i` sampled on the first clock after `rst_n` deasserts, and it keeps that value until the next hard reset. `ext_mdio_oe` stays 0 throughout reset.
- R7: Bit 2 resets to 0 and drives `ext_port_en`. It does not affect the clock outputs or the management routing.
- R8: Writing 1 to bit 0 starts a soft reset, and bit 0 then reads 1 while the request is pending. The request completes once both MAC-side clocks are active. It completes with exactly one cycle of `soft_rst_o`, after which bit 0 reads 0 and the timeout flag (bit 1) is cleared.
- R9: If a pending soft reset sees the MAC-side clocks not both active for `TIMEOUT_CYC` (4096) cycles, bit 1 is set, bit 0 clears, and `soft_rst_o` does not pulse.
- R10: A clock counts as active if it has shown an edge within the last `ACT_WIN` (64) system cycles. A clock with 50 cycles between edges therefore allows a soft reset to complete.
- R11: Writes to bits 15:7, 3 and 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hard reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| int_rx_clk | input | 1 | Internal PHY receive clock |
| int_tx_clk | input | 1 | Internal PHY transmit clock |
| ext_rx_clk | input | 1 | External MII receive clock |
| ext_tx_clk | input | 1 | External MII transmit clock |
| mac_rx_clk | output | 1 | Selected receive clock to MAC |
| mac_tx_clk | output | 1 | Selected transmit clock to MAC |
| ext_port_en | output | 1 | External MII data port enable |
| mac_mdc | input | 1 | MDC from MAC |
| mac_mdio_o | input | 1 | MDIO data out from MAC |
| mac_mdio_oe | input | 1 | MDIO output enable from MAC |
| mac_mdio_i | output | 1 | MDIO data into MAC |
| int_mdc | output | 1 | MDC to internal PHY |
| int_mdio_o | output | 1 | MDIO data to internal PHY |
| int_mdio_oe | output | 1 | MDIO drive enable to internal PHY |
| int_mdio_i | input | 1 | MDIO data from internal PHY |
| ext_mdc | output | 1 | MDC pin |
| ext_mdio_o | output | 1 | MDIO pin data out |
| ext_mdio_oe | output | 1 | MDIO pin output enable |
| ext_mdio_i | input | 1 | MDIO pin input (also strap) |
| soft_rst_o | output | 1 | One-cycle soft reset pulse |

## Verification
The assertions check a set of properties on every cycle:
- the idle drive levels on the unselected management side;
- that both MAC clocks are low under the gated code;
- that the reserved bits are zero;
- that the strap holds after capture;
- that a completed soft reset and a timeout never happen in the same cycle.

Other behaviours can only be shown by the bench's scenarios. These include which clock actually reaches the MAC for each code, where read data for the MAC comes from, and whether read-only bits resist writes. They also include the full 4096-cycle timeout, recovery by a later successful request, and the activity window accepting a slow clock.

// File: rtl/phy_port_sel_pkg.sv
package phy_port_sel_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    CLK_INT     = 2'b00,
    CLK_EXT     = 2'b01,
    CLK_OFF     = 2'b10,
    CLK_INT_ALT = 2'b11
  } clk_src_e;

  localparam int B_PEND  = 0;
  localparam int B_TMO   = 1;
  localparam int B_EXTEN = 2;
  localparam int B_STRAP = 3;
  localparam int B_MGMT  = 4;
  localparam int B_CSEL  = 5;

  localparam int LANES = 2;
  localparam int LANE_RX = 0;
  localparam int LANE_TX = 1;
endpackage

// File: rtl/clk_activity_mon.sv
module clk_activity_mon #(
  parameter int ACT_WIN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic active
);
  localparam int CW = $clog2(ACT_WIN + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      idle_cnt <= CW'(ACT_WIN);
    end else begin
      sync_q <= {sync_q[1:0], mon_clk};
      if (sync_q[2] ^ sync_q[1])
        idle_cnt <= '0;
      else if (idle_cnt < CW'(ACT_WIN))
        idle_cnt <= idle_cnt + 1'b1;
    end
  end

  assign active = (idle_cnt < CW'(ACT_WIN));
endmodule

// File: rtl/srst_ctrl.sv
module srst_ctrl #(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clks_ok,
  output logic pending,
  output logic tmo_flag,
  output logic done_pulse
);
  localparam int TW = $clog2(TIMEOUT_CYC);

  logic [TW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      tmo_flag   <= 1'b0;
      done_pulse <= 1'b0;
      wait_cnt   <= '0;
    end else begin
      done_pulse <= 1'b0;
      if (pending) begin
        if (clks_ok) begin
          pending    <= 1'b0;
          tmo_flag   <= 1'b0;
          done_pulse <= 1'b1;
          wait_cnt   <= '0;
        end else if (wait_cnt == TW'(TIMEOUT_CYC - 1)) begin
          pending  <= 1'b0;
          tmo_flag <= 1'b1;
          wait_cnt <= '0;
        end else begin
          wait_cnt <= wait_cnt + 1'b1;
        end
      end else if (start) begin
        pending  <= 1'b1;
        wait_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/mdio_router.sv
module mdio_router (
  input  logic mgmt_ext,
  input  logic hold_ext_off,
  input  logic mac_mdc,
  input  logic mac_mdio_o,
  input  logic mac_mdio_oe,
  output logic mac_mdio_i,
  output logic int_mdc,
  output logic int_mdio_o,
  output logic int_mdio_oe,
  input  logic int_mdio_i,
  output logic ext_mdc,
  output logic ext_mdio_o,
  output logic ext_mdio_oe,
  input  logic ext_mdio_i
);
  always_comb begin
    if (mgmt_ext) begin
      int_mdc     = 1'b0;
      int_mdio_o  = 1'b0;
      int_mdio_oe = 1'b1;
      ext_mdc     = mac_mdc;
      ext_mdio_o  = mac_mdio_o;
      ext_mdio_oe = mac_mdio_oe & ~hold_ext_off;
      mac_mdio_i  = ext_mdio_i;
    end else begin
      int_mdc     = mac_mdc;
      int_mdio_o  = mac_mdio_o;
      int_mdio_oe = mac_mdio_oe;
      ext_mdc     = 1'b0;
      ext_mdio_o  = 1'b0;
      ext_mdio_oe = 1'b0;
      mac_mdio_i  = int_mdio_i;
    end
  end
endmodule

// File: rtl/phy_port_sel.sv
module phy_port_sel
  import phy_port_sel_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int CTRL_ADDR   = 0,
  parameter int ACT_WIN     = 64,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              int_rx_clk,
  input  logic              int_tx_clk,
  input  logic              ext_rx_clk,
  input  logic              ext_tx_clk,
  output logic              mac_rx_clk,
  output logic              mac_tx_clk,
  output logic              ext_port_en,
  input  logic              mac_mdc,
  input  logic              mac_mdio_o,
  input  logic              mac_mdio_oe,
  output logic              mac_mdio_i,
  output logic              int_mdc,
  output logic              int_mdio_o,
  output logic              int_mdio_oe,
  input  logic              int_mdio_i,
  output logic              ext_mdc,
  output logic              ext_mdio_o,
  output logic              ext_mdio_oe,
  input  logic              ext_mdio_i,
  output logic              soft_rst_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

  clk_src_e clk_sel_q;
  logic     mgmt_ext_q, ext_en_q, strap_q, strap_done;
  logic     srst_pending, tmo_flag, clks_ok, srst_start, wr_ctrl;
  logic [LANES-1:0] in_int, in_ext, lane_out, lane_act;
  logic [REG_W-1:0] reg_view;

  assign wr_ctrl    = bus_we && (bus_addr == A_CTRL);
  assign srst_start = wr_ctrl && bus_wdata[B_PEND];

  // Host-writable fields and strap capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel_q  <= CLK_INT;
      mgmt_ext_q <= 1'b0;
      ext_en_q   <= 1'b0;
      strap_q    <= 1'b0;
      strap_done <= 1'b0;
    end else begin
      if (!strap_done) begin
        strap_q    <= ext_mdio_i;
        strap_done <= 1'b1;
      end
      if (wr_ctrl) begin
        clk_sel_q  <= clk_src_e'(bus_wdata[B_CSEL +: 2]);
        mgmt_ext_q <= bus_wdata[B_MGMT];
        ext_en_q   <= bus_wdata[B_EXTEN];
      end
    end
  end

  always_comb begin
    reg_view            = '0;
    reg_view[B_CSEL+:2] = clk_sel_q;
    reg_view[B_MGMT]    = mgmt_ext_q;
    reg_view[B_STRAP]   = strap_q;
    reg_view[B_EXTEN]   = ext_en_q;
    reg_view[B_TMO]     = tmo_flag;
    reg_view[B_PEND]    = srst_pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= (bus_addr == A_CTRL) ? reg_view : '0;
  end

  // Per-lane clock selection and activity detection
  assign in_int = {int_tx_clk, int_rx_clk};
  assign in_ext = {ext_tx_clk, ext_rx_clk};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      unique case (clk_sel_q)
        CLK_EXT: lane_out[g] = in_ext[g];
        CLK_OFF: lane_out[g] = 1'b0;
        default: lane_out[g] = in_int[g];
      endcase
    end

    clk_activity_mon #(.ACT_WIN(ACT_WIN)) u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .mon_clk (lane_out[g]),
      .active  (lane_act[g])
    );
  end

  assign mac_rx_clk  = lane_out[LANE_RX];
  assign mac_tx_clk  = lane_out[LANE_TX];
  assign clks_ok     = &lane_act;
  assign ext_port_en = ext_en_q;

  srst_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_srst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (srst_start),
    .clks_ok    (clks_ok),
    .pending    (srst_pending),
    .tmo_flag   (tmo_flag),
    .done_pulse (soft_rst_o)
  );

  mdio_router u_mdio (
    .mgmt_ext     (mgmt_ext_q),
    .hold_ext_off (~strap_done),
    .mac_mdc      (mac_mdc),
    .mac_mdio_o   (mac_mdio_o),
    .mac_mdio_oe  (mac_mdio_oe),
    .mac_mdio_i   (mac_mdio_i),
    .int_mdc      (int_mdc),
    .int_mdio_o   (int_mdio_o),
    .int_mdio_oe  (int_mdio_oe),
    .int_mdio_i   (int_mdio_i),
    .ext_mdc      (ext_mdc),
    .ext_mdio_o   (ext_mdio_o),
    .ext_mdio_oe  (ext_mdio_oe),
    .ext_mdio_i   (ext_mdio_i)
  );
endmodule

// File: rtl/phy_port_sel_chk.sv
module phy_port_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_rdata,
  input logic [1:0]  clk_sel,
  input logic        mgmt_ext,
  input logic        mac_rx_clk,
  input logic        mac_tx_clk,
  input logic        int_mdc,
  input logic        int_mdio_o,
  input logic        int_mdio_oe,
  input logic        ext_mdc,
  input logic        ext_mdio_oe,
  input logic        strap_done,
  input logic        strap_q,
  input logic        soft_rst_o,
  input logic        tmo_flag,
  input logic        srst_pending
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[15:7] == 9'd0);

  p_clk_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b10) |-> (!mac_rx_clk && !mac_tx_clk));

  p_ext_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mgmt_ext |-> (!ext_mdc && !ext_mdio_oe));

  p_int_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_ext |-> (!int_mdc && !int_mdio_o && int_mdio_oe));

  p_strap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(strap_q));

  p_srst_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (!tmo_flag && !srst_pending));

  p_tmo_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> (!soft_rst_o && !srst_pending));
endmodule

bind phy_port_sel phy_port_sel_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_rdata    (bus_rdata),
  .clk_sel      (clk_sel_q),
  .mgmt_ext     (mgmt_ext_q),
  .mac_rx_clk   (mac_rx_clk),
  .mac_tx_clk   (mac_tx_clk),
  .int_mdc      (int_mdc),
  .int_mdio_o   (int_mdio_o),
  .int_mdio_oe  (int_mdio_oe),
  .ext_mdc      (ext_mdc),
  .ext_mdio_oe  (ext_mdio_oe),
  .strap_done   (strap_done),
  .strap_q      (strap_q),
  .soft_rst_o   (soft_rst_o),
  .tmo_flag     (tmo_flag),
  .srst_pending (srst_pending)
);

// File: tb/tb_phy_port_sel.sv
`timescale 1ns/1ps
module tb_phy_port_sel;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = 0;
  logic bus_we = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic int_rx_clk = 0, int_tx_clk = 0, ext_rx_clk = 0, ext_tx_clk = 0;
  logic mac_rx_clk, mac_tx_clk, ext_port_en;
  logic mac_mdc = 0, mac_mdio_o = 0, mac_mdio_oe = 0, mac_mdio_i;
  logic int_mdc, int_mdio_o, int_mdio_oe, int_mdio_i = 0;
  logic ext_mdc, ext_mdio_o, ext_mdio_oe, ext_mdio_i = 1;
  logic soft_rst_o;

  int tests = 0, fails = 0, pulses = 0;
  int ext_half = 16;
  bit ext_run = 1, finished = 0;

  typedef struct { logic [15:0] exp; string tag; } rd_item_t;
  rd_item_t sb_q[$];
  event rd_ev;

  phy_port_sel dut (.*);

  always #2 clk = ~clk;
  always #20 int_rx_clk = ~int_rx_clk;
  initial begin #7; forever #20 int_tx_clk = ~int_tx_clk; end
  initial forever begin #(ext_half); ext_rx_clk = ext_run ? ~ext_rx_clk : 1'b0; end
  initial begin #5; forever begin #(ext_half); ext_tx_clk = ext_run ? ~ext_tx_clk : 1'b0; end end

  always @(negedge clk) if (soft_rst_o) pulses++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    rd_item_t it;
    @(rd_ev);
    @(negedge clk);
    it = sb_q.pop_front();
    chk(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
  end

  task automatic wr(input logic [15:0] d);
    @(negedge clk); bus_addr = 0; bus_we = 1; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    rd_item_t it;
    @(negedge clk); bus_addr = a;
    @(posedge clk);
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    ->rd_ev;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    idle(3);
    chk(ext_mdio_oe === 1'b0, "R6 oe low in reset", ext_mdio_oe, 0);
    rst_n = 1;
    idle(2);
    ext_mdio_i = 0;
    rd(0, 16'h0008, "R2 R6 reset value with strap high");
    rd(0, 16'h0008, "R6 strap holds after pin change");
    rd(1, 16'h0000, "R1 other address reads zero");
    chk(mac_rx_clk === int_rx_clk && mac_tx_clk === int_tx_clk, "R2 code 00 internal", mac_rx_clk, int_rx_clk);
    mac_mdc = 1; mac_mdio_o = 1; mac_mdio_oe = 1; int_mdio_i = 1; idle(1);
    chk({int_mdc, int_mdio_o, int_mdio_oe, mac_mdio_i} === 4'b1111, "R4 internal route", {int_mdc, int_mdio_o, int_mdio_oe, mac_mdio_i}, 4'b1111);
    chk({ext_mdc, ext_mdio_oe} === 2'b00, "R4 external idle", {ext_mdc, ext_mdio_oe}, 0);

    wr(16'hFF8A);
    rd(0, 16'h0008, "R11 read-only and reserved writes ignored");
    chk(ext_port_en === 1'b0, "R11 ext enable untouched", ext_port_en, 0);

    wr(16'h0020); idle(1);
    rd(0, 16'h0028, "R2 code 01 stored");
    chk(mac_rx_clk === ext_rx_clk && mac_tx_clk === ext_tx_clk, "R2 code 01 external", mac_rx_clk, ext_rx_clk);
    chk({ext_mdc, ext_mdio_oe, int_mdc} === 3'b001, "R3 routing unaffected by clock select", {ext_mdc, ext_mdio_oe, int_mdc}, 3'b001);
    chk(ext_port_en === 1'b0, "R3 port enable unaffected", ext_port_en, 0);
    wr(16'h0040); idle(15);
    chk({mac_rx_clk, mac_tx_clk} === 2'b00, "R2 code 10 gated", {mac_rx_clk, mac_tx_clk}, 0);
    wr(16'h0060); idle(1);
    chk(mac_rx_clk === int_rx_clk && mac_tx_clk === int_tx_clk, "R2 code 11 internal", mac_rx_clk, int_rx_clk);

    wr(16'h0010); idle(1);
    ext_mdio_i = 1; int_mdio_i = 0; idle(1);
    chk({ext_mdc, ext_mdio_o, ext_mdio_oe, mac_mdio_i} === 4'b1111, "R5 external route", {ext_mdc, ext_mdio_o, ext_mdio_oe, mac_mdio_i}, 4'hF);
    chk({int_mdc, int_mdio_o, int_mdio_oe} === 3'b001, "R5 internal driven low", {int_mdc, int_mdio_o, int_mdio_oe}, 3'b001);
    chk(ext_port_en === 1'b0, "R5 independent of port enable", ext_port_en, 0);

    wr(16'h0004); idle(1);
    chk(ext_port_en === 1'b1, "R7 port enable set", ext_port_en, 1);
    chk(mac_rx_clk === int_rx_clk && int_mdc === 1'b1 && ext_mdc === 1'b0, "R7 no effect on clocks or mdio", {mac_rx_clk, int_mdc, ext_mdc}, {int_rx_clk, 2'b10});

    wr(16'h0000); idle(20);
    p0 = pulses;
    wr(16'h0001); idle(50);
    chk(pulses - p0 == 1, "R8 soft reset pulses once", pulses - p0, 1);
    rd(0, 16'h0008, "R8 pending cleared after success");

    wr(16'h0040); idle(80);
    p0 = pulses;
    wr(16'h0041); idle(100);
    rd(0, 16'h0049, "R8 pending reads one while waiting");
    idle(4100);
    rd(0, 16'h004A, "R9 timeout flag set, pending cleared");
    chk(pulses == p0, "R9 no pulse on timeout", pulses - p0, 0);

    p0 = pulses;
    wr(16'h0001); idle(50);
    rd(0, 16'h0008, "R8 later success clears timeout");
    chk(pulses - p0 == 1, "R8 recovery pulse", pulses - p0, 1);

    ext_half = 200;
    wr(16'h0020); idle(200);
    p0 = pulses;
    wr(16'h0021); idle(300);
    chk(pulses - p0 == 1, "R10 slow clock within window counts active", pulses - p0, 1);
    rd(0, 16'h0028, "R10 no timeout with slow clock");

    idle(5);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule